// File: doc/BRIEF.md
# Receive Character Matcher with Flow Control

This per-channel unit watches every character the receiver delivers and compares it with three programmable slot characters. Depending on the automation level, a match can simply raise an event and a sticky flag, pause or resume the local transmitter (software flow control with XON/XOFF characters), or act as the station address that wakes the receiver in a multi-drop network where the ninth bit marks address characters. The unit also runs hardware flow control. It drops RTS when the receive buffer fill level reaches a threshold. It stops new transmit starts while CTS is low.

Slot 0 holds the station address, slot 1 the XON character and slot 2 the XOFF character. Every slot always works as a general match. The automation level `auto_lvl` selects the action: 2'b00 match only, 2'b01 XON/XOFF, 2'b10 address wake-up, 2'b11 address wake-up plus XON/XOFF. Bit 0 enables pausing and bit 1 enables address mode.

There are three state machines. The wake machine has the states ASLEEP and AWAKE. An address character equal to slot 0 takes it from ASLEEP to AWAKE (transition WAKE). Any other address character takes it back to ASLEEP (transition DOZE). Leaving address mode also forces ASLEEP. The pause machine has the states RUN and HELD. A matching XOFF takes it from RUN to HELD (transition STOP). A matching XON takes it from HELD to RUN (transition RESUME). Leaving XON/XOFF mode forces RUN. The RTS machine has the states ASSERT and DROP. Reaching the fill threshold takes it from ASSERT to DROP (transition FULL). Falling below the threshold takes it from DROP to ASSERT (transition DRAIN). Disabling hardware flow control forces ASSERT.

Top module: `char_match_flow`

## Requirements
- R1: After reset, `match_evt` and `match_sticky` are all zero, `rts` is 1, `tx_hold` is 0 while `cts` is 1, and `rx_en` is 1 at level 2'b00.
- R2: One clock after an accepted character strobe, `match_evt[i]` pulses high for exactly one cycle for each slot i whose character equals `rx_data`. A character that matches no slot gives no event.
- R3: `match_sticky[i]` is set together with `match_evt[i]` and stays set until `clr_sticky[i]` is high at a clock edge. When a set and a clear fall in the same cycle, the set wins.
- R4: At levels 2'b10 and 2'b11, `rx_en` is 0 until an address character (`rx_addr`=1) equal to slot 0 arrives, and it is 1 from the next cycle. An address character that differs from slot 0 clears it. While `rx_en` is 0, data characters raise no events and cause no pausing.
- R5: At levels 2'b00 and 2'b01, `rx_addr` is ignored, and every character is compared and accepted as data.
- R6: At levels 2'b01 and 2'b11, an accepted data character equal to slot 2 (XOFF) sets `tx_hold` one cycle later. One equal to slot 1 (XON) clears it. If slots 1 and 2 are equal, XOFF wins.
- R7: At levels 2'b00 and 2'b10, XON and XOFF characters still raise events but never change `tx_hold`. Switching to such a level releases a pause one cycle later.
- R8: `tx_go` equals `tx_req` AND NOT `tx_hold` in the same cycle. A pause therefore blocks only the start of a new character and never cuts one short.
- R9: With `hw_flow_en`=1, `rts` goes to 0 the cycle after `fill_level` >= `rts_thresh` and returns to 1 the cycle after `fill_level` < `rts_thresh`.
- R10: With `hw_flow_en`=1, `cts`=0 forces `tx_hold` high in the same cycle. With `hw_flow_en`=0, `rts` is 1 and `cts` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_lvl | input | 2 | Automation level (bit0 XON/XOFF, bit1 address mode) |
| slot_chars | input | NSLOT*DW | Slot characters, slot i at bits [i*DW +: DW] |
| rx_stb | input | 1 | Received character strobe, one cycle |
| rx_data | input | DW | Received character |
| rx_addr | input | 1 | Ninth bit: character is an address |
| clr_sticky | input | NSLOT | Clear command per sticky flag |
| hw_flow_en | input | 1 | Enable RTS/CTS flow control |
| fill_level | input | FILL_W | Receive buffer fill level |
| rts_thresh | input | FILL_W | Fill level at which RTS drops |
| cts | input | 1 | Clear to send from the remote side, high = clear |
| tx_req | input | 1 | Transmitter wants to start a character |
| match_evt | output | NSLOT | One-cycle match pulses |
| match_sticky | output | NSLOT | Sticky match flags |
| rx_en | output | 1 | Receiver accepts data characters |
| tx_hold | output | 1 | Transmitter must not start a new character |
| tx_go | output | 1 | Transmit start permitted this cycle |
| rts | output | 1 | Request to send to the remote side |

## Verification
The bench targets the moment `rx_en` changes. A design that updates the wake state before it qualifies the current character would accept the address character itself, or the first data character after a bad address, as data. The bench also drives a set and a clear of a sticky flag in the same cycle, where a clear-first design would lose the match. It sets XON and XOFF to the same character, where the wrong priority leaves the transmitter running. Finally, it exercises the exact fill threshold and a disabled hardware flow control. An off-by-one compare keeps RTS high at the threshold, and a missing enable lets CTS hold the transmitter.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
    typedef enum logic [1:0] {
        LVL_MATCH    = 2'b00,
        LVL_XON      = 2'b01,
        LVL_ADDR     = 2'b10,
        LVL_ADDR_XON = 2'b11
    } auto_lvl_e;

    typedef enum logic {WK_ASLEEP, WK_AWAKE} wake_e;
    typedef enum logic {PS_RUN, PS_HELD} pause_e;
    typedef enum logic {RT_ASSERT, RT_DROP} rts_e;

    localparam int SLOT_ADDR = 0;
    localparam int SLOT_XON  = 1;
    localparam int SLOT_XOFF = 2;
endpackage

// File: rtl/cmf_match.sv
module cmf_match #(
    parameter int DW    = 8,
    parameter int NSLOT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       rx_data,
    input  logic [NSLOT*DW-1:0] slot_chars,
    input  logic [NSLOT-1:0]    qual,
    input  logic [NSLOT-1:0]    clr,
    output logic [NSLOT-1:0]    hit,
    output logic [NSLOT-1:0]    evt_q,
    output logic [NSLOT-1:0]    sticky_q
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign hit[i] = (rx_data == slot_chars[i*DW +: DW]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_q[i]    <= 1'b0;
                sticky_q[i] <= 1'b0;
            end else begin
                evt_q[i] <= qual[i] && hit[i];
                if (qual[i] && hit[i])
                    sticky_q[i] <= 1'b1;
                else if (clr[i])
                    sticky_q[i] <= 1'b0;
            end
        end

        // R3
        sticky_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_q[i] |-> sticky_q[i]);

        // R3
        sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !(qual[i] && hit[i])) |=> !sticky_q[i]);
    end
endmodule

// File: rtl/cmf_wake.sv
module cmf_wake
    import cmf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_mode,
    input  logic addr_stb,
    input  logic addr_hit,
    output logic awake
);
    wake_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_ASLEEP: if (addr_mode && addr_stb && addr_hit) state_d = WK_AWAKE;
            WK_AWAKE:  if (!addr_mode || (addr_stb && !addr_hit)) state_d = WK_ASLEEP;
            default:   state_d = WK_ASLEEP;
        endcase
        if (!addr_mode) state_d = WK_ASLEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_ASLEEP;
        else        state_q <= state_d;
    end

    always_comb awake = (state_q == WK_AWAKE);

    // R4
    bad_addr_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && addr_stb && !addr_hit) |=> !awake);

    // R4
    good_addr_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && addr_stb && addr_hit) |=> awake);
endmodule

// File: rtl/cmf_pause.sv
module cmf_pause
    import cmf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xon_mode,
    input  logic data_ok,
    input  logic hit_xon,
    input  logic hit_xoff,
    output logic held
);
    pause_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:  if (xon_mode && data_ok && hit_xoff) state_d = PS_HELD;
            PS_HELD: if (!xon_mode || (data_ok && hit_xon && !hit_xoff)) state_d = PS_RUN;
            default: state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    always_comb held = (state_q == PS_HELD);

    // R6
    xoff_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xon_mode && data_ok && hit_xoff) |=> held);

    // R7
    no_mode_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xon_mode |=> !held);
endmodule

// File: rtl/cmf_rts.sv
module cmf_rts
    import cmf_pkg::*;
#(
    parameter int FILL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_en,
    input  logic [FILL_W-1:0] fill,
    input  logic [FILL_W-1:0] thresh,
    output logic              rts
);
    rts_e state_q, state_d;
    logic at_limit;

    assign at_limit = (fill >= thresh);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_ASSERT: if (flow_en && at_limit) state_d = RT_DROP;
            RT_DROP:   if (!flow_en || !at_limit) state_d = RT_ASSERT;
            default:   state_d = RT_ASSERT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RT_ASSERT;
        else        state_q <= state_d;
    end

    always_comb rts = !flow_en || (state_q == RT_ASSERT);

    // R9
    full_drops_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && at_limit) |=> (!rts || !flow_en));

    // R9
    drain_raises_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !at_limit |=> rts);
endmodule

// File: rtl/char_match_flow.sv
module char_match_flow
    import cmf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NSLOT  = 3,
    parameter int FILL_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          auto_lvl,
    input  logic [NSLOT*DW-1:0] slot_chars,
    input  logic                rx_stb,
    input  logic [DW-1:0]       rx_data,
    input  logic                rx_addr,
    input  logic [NSLOT-1:0]    clr_sticky,
    input  logic                hw_flow_en,
    input  logic [FILL_W-1:0]   fill_level,
    input  logic [FILL_W-1:0]   rts_thresh,
    input  logic                cts,
    input  logic                tx_req,
    output logic [NSLOT-1:0]    match_evt,
    output logic [NSLOT-1:0]    match_sticky,
    output logic                rx_en,
    output logic                tx_hold,
    output logic                tx_go,
    output logic                rts
);
    localparam int XON_BIT  = 0;
    localparam int ADDR_BIT = 1;

    logic             addr_mode, xon_mode, awake, data_ok, held;
    logic [NSLOT-1:0] hit, qual;

    assign addr_mode = auto_lvl[ADDR_BIT];
    assign xon_mode  = auto_lvl[XON_BIT];
    assign rx_en     = !addr_mode || awake;
    assign data_ok   = rx_stb && rx_en && !(addr_mode && rx_addr);

    for (genvar i = 0; i < NSLOT; i++) begin : g_qual
        if (i == SLOT_ADDR) begin : g_addr
            assign qual[i] = addr_mode ? (rx_stb && rx_addr) : data_ok;
        end else begin : g_data
            assign qual[i] = data_ok;
        end
    end

    cmf_match #(.DW(DW), .NSLOT(NSLOT)) u_match (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .slot_chars(slot_chars),
        .qual(qual), .clr(clr_sticky), .hit(hit),
        .evt_q(match_evt), .sticky_q(match_sticky)
    );

    cmf_wake u_wake (
        .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode),
        .addr_stb(rx_stb && rx_addr), .addr_hit(hit[SLOT_ADDR]), .awake(awake)
    );

    cmf_pause u_pause (
        .clk(clk), .rst_n(rst_n), .xon_mode(xon_mode), .data_ok(data_ok),
        .hit_xon(hit[SLOT_XON]), .hit_xoff(hit[SLOT_XOFF]), .held(held)
    );

    cmf_rts #(.FILL_W(FILL_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .flow_en(hw_flow_en),
        .fill(fill_level), .thresh(rts_thresh), .rts(rts)
    );

    assign tx_hold = held || (hw_flow_en && !cts);
    assign tx_go   = tx_req && !tx_hold;

    // R4
    asleep_no_data_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && !rx_en && rx_stb && !rx_addr) |=> (match_evt == '0));

    // R10
    cts_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_flow_en && !cts && tx_req) |-> !tx_go);
endmodule

// File: tb/tb_char_match_flow.sv
module tb_char_match_flow;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  auto_lvl;
    logic [23:0] slot_chars;
    logic        rx_stb, rx_addr, hw_flow_en, cts, tx_req;
    logic [7:0]  rx_data;
    logic [2:0]  clr_sticky;
    logic [8:0]  fill_level, rts_thresh;
    logic [2:0]  match_evt, match_sticky;
    logic        rx_en, tx_hold, tx_go, rts;

    int n_chk = 0, n_fail = 0;
    logic [2:0] exp_q[$];
    logic       stb_d = 1'b0;
    logic       m_awake = 1'b0, m_paused = 1'b0;
    logic [2:0] m_sticky = 3'b000;

    always #10 clk = ~clk;

    char_match_flow dut (
        .clk(clk), .rst_n(rst_n), .auto_lvl(auto_lvl), .slot_chars(slot_chars),
        .rx_stb(rx_stb), .rx_data(rx_data), .rx_addr(rx_addr), .clr_sticky(clr_sticky),
        .hw_flow_en(hw_flow_en), .fill_level(fill_level), .rts_thresh(rts_thresh),
        .cts(cts), .tx_req(tx_req), .match_evt(match_evt), .match_sticky(match_sticky),
        .rx_en(rx_en), .tx_hold(tx_hold), .tx_go(tx_go), .rts(rts)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) stb_d <= rx_stb;

    // scoreboard monitor: event vector one cycle after each strobe (R2)
    always @(negedge clk) begin
        if (stb_d) begin
            if (exp_q.size() == 0) chk("R2 unexpected event slot", 32'(match_evt), 32'hdead);
            else chk("R2 match_evt", 32'(match_evt), 32'(exp_q.pop_front()));
        end
    end

    task automatic send(input logic [7:0] d, input logic a, input logic [2:0] clr);
        logic [2:0] hit, m;
        logic am, ok;
        for (int i = 0; i < 3; i++) hit[i] = (d == slot_chars[i*8 +: 8]);
        am   = auto_lvl[1];
        ok   = !am || (m_awake && !a);
        m[0] = hit[0] && (am ? a : ok);
        m[1] = hit[1] && ok;
        m[2] = hit[2] && ok;
        if (am && a) m_awake = hit[0];
        if (auto_lvl[0] && ok) begin
            if (hit[2]) m_paused = 1'b1;
            else if (hit[1]) m_paused = 1'b0;
        end
        for (int i = 0; i < 3; i++)
            if (m[i]) m_sticky[i] = 1'b1;
            else if (clr[i]) m_sticky[i] = 1'b0;
        @(negedge clk);
        rx_data = d; rx_addr = a; rx_stb = 1'b1; clr_sticky = clr;
        exp_q.push_back(m);
        @(negedge clk);
        rx_stb = 1'b0; rx_addr = 1'b0; clr_sticky = 3'b000;
    endtask

    task automatic set_lvl(input logic [1:0] v);
        @(negedge clk);
        auto_lvl = v;
        if (!v[1]) m_awake = 1'b0;
        if (!v[0]) m_paused = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; auto_lvl = 2'b00; slot_chars = {8'h13, 8'h11, 8'h41};
        rx_stb = 1'b0; rx_data = 8'h00; rx_addr = 1'b0; clr_sticky = 3'b000;
        hw_flow_en = 1'b0; fill_level = 9'd0; rts_thresh = 9'd200; cts = 1'b1; tx_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 evt", 32'(match_evt), 0);
        chk("R1 sticky", 32'(match_sticky), 0);
        chk("R1 rts", 32'(rts), 1);
        chk("R1 tx_hold", 32'(tx_hold), 0);
        chk("R1 rx_en", 32'(rx_en), 1);

        // R2, R3 general matching at level 00
        send(8'h41, 1'b0, 3'b000);
        chk("R3 sticky set", 32'(match_sticky), 32'(m_sticky));
        send(8'h55, 1'b0, 3'b000);
        send(8'h13, 1'b0, 3'b000);
        chk("R7 xoff ignored at level 00", 32'(tx_hold), 0);
        // R5 ninth bit ignored
        send(8'h11, 1'b1, 3'b000);
        chk("R5 addr bit ignored sticky", 32'(match_sticky), 3'b111);
        // R3 clear, then set wins over clear
        send(8'h55, 1'b0, 3'b111);
        chk("R3 clear", 32'(match_sticky), 0);
        send(8'h41, 1'b0, 3'b011);
        chk("R3 set wins", 32'(match_sticky), 32'(m_sticky));

        // R6, R8 software flow control
        set_lvl(2'b01);
        tx_req = 1'b1;
        send(8'h13, 1'b0, 3'b000);
        chk("R6 xoff holds", 32'(tx_hold), 1);
        chk("R8 tx_go blocked", 32'(tx_go), 0);
        send(8'h11, 1'b0, 3'b000);
        chk("R6 xon resumes", 32'(tx_hold), 0);
        chk("R8 tx_go passes", 32'(tx_go), 1);
        slot_chars[15:8] = 8'h13;
        send(8'h13, 1'b0, 3'b000);
        chk("R6 xoff wins tie", 32'(tx_hold), 1);
        slot_chars[15:8] = 8'h11;
        set_lvl(2'b00);
        chk("R7 leaving mode releases", 32'(tx_hold), 0);

        // R4 address wake-up
        set_lvl(2'b10);
        chk("R4 asleep after entry", 32'(rx_en), 0);
        send(8'h41, 1'b0, 3'b000);
        send(8'h41, 1'b1, 3'b000);
        chk("R4 address wakes", 32'(rx_en), 1);
        send(8'h13, 1'b0, 3'b000);
        chk("R7 xoff ignored at level 10", 32'(tx_hold), 0);
        send(8'h22, 1'b1, 3'b000);
        chk("R4 other address sleeps", 32'(rx_en), 0);

        set_lvl(2'b11);
        send(8'h13, 1'b0, 3'b000);
        chk("R4 asleep no pause", 32'(tx_hold), 0);
        send(8'h41, 1'b1, 3'b000);
        send(8'h13, 1'b0, 3'b000);
        chk("R6 xoff when awake", 32'(tx_hold), 1);
        send(8'h11, 1'b0, 3'b000);
        chk("R6 xon when awake", 32'(tx_hold), 0);
        set_lvl(2'b00);

        // R9, R10 hardware flow control
        hw_flow_en = 1'b1; fill_level = 9'd199;
        @(negedge clk);
        chk("R9 below threshold", 32'(rts), 1);
        fill_level = 9'd200;
        @(negedge clk);
        chk("R9 at threshold", 32'(rts), 0);
        fill_level = 9'd150;
        @(negedge clk);
        chk("R9 drained", 32'(rts), 1);
        cts = 1'b0;
        #1;
        chk("R10 cts holds", 32'(tx_hold), 1);
        chk("R10 cts blocks go", 32'(tx_go), 0);
        hw_flow_en = 1'b0; fill_level = 9'd250;
        @(negedge clk);
        @(negedge clk);
        chk("R10 disabled rts", 32'(rts), 1);
        chk("R10 disabled cts", 32'(tx_hold), 0);

        repeat (2) @(negedge clk);
        chk("R2 all events seen", 32'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule